// File: doc/BRIEF.md
# Block-Mode Video Memory Copy Engine

This engine copies data into video RAM in fixed blocks of 16 bytes. Software loads a source address and a destination offset through byte-wide registers. It then writes a control byte that picks the mode and the number of blocks. In general mode the blocks run back to back until the whole transfer is done. In blank-paced mode one block is copied each time the display enters its horizontal-blank period. Software can use this to update video memory between scanlines.

Each block reads 16 consecutive source bytes and writes them to consecutive video RAM addresses, one byte per clock. The source memory answers in the same cycle as the request. After each block the engine gives a one-cycle stall request to the processor. The request carries a stall length that depends on whether the system runs at normal or double speed. A transfer ends when its block count runs out or when the destination reaches the end of the video RAM window.

Top module: `vram_block_dma`

## Requirements
- R1: Register select 0 sets source bits 15:8 and select 1 sets source bits 7:0. The low four bits of the select-1 byte are forced to zero. Block k of a transfer reads source addresses start + 16k to start + 16k + 15, which wrap at 16 bits.
- R2: Register select 2 keeps its low five bits as offset bits 12:8. Register select 3 gives offset bits 7:0 with the low nibble cleared. Every video write goes to address 0x8000 OR offset, and the offset increases by one for each byte.
- R3: A write to select 4 while idle starts a transfer. Data bit 7 = 0 selects general mode and bit 7 = 1 selects blank-paced mode. Bits 6:0 give N, and N + 1 blocks are copied. In general mode the blocks follow each other with no gap, one byte per clock, and the write data is the byte read from the source address of the same cycle.
- R4: In blank-paced mode a block starts only on a low-to-high change of `hblank_in`. A level that stays high starts nothing, including a level that was already high when the mode started.
- R5: A transfer whose count runs out finishes with the remaining-length field equal to 0x7F, and both modes are cleared.
- R6: A transfer ends at once when the offset reaches 0x2000 after a block, even if blocks remain. The offset wraps to 0, so the next transfer that does not reload it starts at 0x8000.
- R7: Reading select 4 returns bit 7 = NOT(blank-paced mode active) and bits 6:0 = remaining length. After reset this read gives 0xFF.
- R8: A select-4 write during blank-paced mode cancels it, and no later blank edge copies a block. A select-4 write during a general transfer has no effect.
- R9: One cycle after each block, `stall_req` is high for exactly one cycle. At the same time `stall_cycles` is 8 when `double_speed` is 0 and 16 when it is 1.
- R10: Reads of selects 0 to 3 and of the unused selects 5 to 7 return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_sel` |
| src_rd_en | output | 1 | Source read request |
| src_rd_addr | output | 16 | Source byte address |
| src_rd_data | input | 8 | Source byte, valid in the same cycle |
| vram_wr_en | output | 1 | Video RAM write strobe |
| vram_wr_addr | output | 16 | Video RAM byte address |
| vram_wr_data | output | 8 | Video RAM write data |
| hblank_in | input | 1 | Horizontal-blank status from the display |
| double_speed | input | 1 | System runs at double speed |
| stall_req | output | 1 | One-cycle processor stall request |
| stall_cycles | output | 5 | Stall length that goes with `stall_req` |

## Verification
The bench builds the engine with its default parameters: 16-byte blocks, a 7-bit length field, a 13-bit video offset and stall lengths of 8 and 16. With these values a destination loaded near 0x1FE0 reaches the window end within two blocks, and a source at 0xFFF0 wraps after one block. Both boundaries therefore come up in short runs. A transfer that ends when its count runs out leaves 0x7F as the remaining length, so the control readback after such a transfer shows the underflow directly.

// File: rtl/vdma_pkg.sv
// Shared constants for the video memory block copy engine.
// Assumes an 8-bit register port and a 7-bit length field in the control byte.
package vdma_pkg;
    typedef logic [7:0] byte_t;

    localparam int          LEN_W       = 7;
    localparam logic [2:0]  SEL_SRC_HI  = 3'd0;
    localparam logic [2:0]  SEL_SRC_LO  = 3'd1;
    localparam logic [2:0]  SEL_DST_HI  = 3'd2;
    localparam logic [2:0]  SEL_DST_LO  = 3'd3;
    localparam logic [2:0]  SEL_CTRL    = 3'd4;
endpackage

// File: rtl/vdma_regfile.sv
// Register file and transfer state: source, destination offset, length, modes.
// Advances the pointers after each block and decides when a transfer ends.
// Assumes blk_done is high only in the last byte cycle of a block.
module vdma_regfile
    import vdma_pkg::*;
#(
    parameter int OFS_W     = 13,
    parameter int BLK_BYTES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       sel,
    input  byte_t            wdata,
    output byte_t            rdata,
    input  logic             blk_done,
    input  logic             busy,
    output logic [15:0]      src_base,
    output logic [OFS_W-1:0] dst_base,
    output logic             gen_mode,
    output logic             hb_mode,
    output logic             last_blk
);
    localparam int    IDX_W   = $clog2(BLK_BYTES);
    localparam int    DH_W    = OFS_W - 8;
    localparam byte_t LO_MASK = byte_t'(8'hFF << IDX_W);

    logic [LEN_W-1:0] len_q;
    logic [OFS_W:0]   dst_sum;
    logic             idle;

    // Next destination offset with one extra carry bit used for the window end
    assign dst_sum  = {1'b0, dst_base} + (OFS_W+1)'(BLK_BYTES);
    assign last_blk = (len_q == '0) || dst_sum[OFS_W];
    assign idle     = !gen_mode && !hb_mode && !busy;

    // Read mux: only the control byte holds state that can be read
    always_comb begin
        rdata = 8'hFF;
        if (sel == SEL_CTRL) rdata = {~hb_mode, len_q};
    end

    // Register writes, block advance and the end-of-transfer decision
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_base <= '0;
            dst_base <= '0;
            len_q    <= '1;
            gen_mode <= 1'b0;
            hb_mode  <= 1'b0;
        end else begin
            if (wr_en) begin
                case (sel)
                    SEL_SRC_HI: src_base[15:8]       <= wdata;
                    SEL_SRC_LO: src_base[7:0]        <= wdata & LO_MASK;
                    SEL_DST_HI: dst_base[OFS_W-1:8]  <= wdata[DH_W-1:0];
                    SEL_DST_LO: dst_base[7:0]        <= wdata & LO_MASK;
                    SEL_CTRL: begin
                        if (hb_mode) begin
                            hb_mode <= 1'b0;
                        end else if (idle) begin
                            hb_mode  <= wdata[7];
                            gen_mode <= ~wdata[7];
                            len_q    <= wdata[LEN_W-1:0];
                        end
                    end
                    default: ;
                endcase
            end
            if (blk_done) begin
                src_base <= src_base + 16'(BLK_BYTES);
                dst_base <= dst_sum[OFS_W-1:0];
                len_q    <= len_q - 1'b1;
                if (last_blk) begin
                    gen_mode <= 1'b0;
                    hb_mode  <= 1'b0;
                end
            end
        end
    end

    AST_MODES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(gen_mode && hb_mode)); // R3
    AST_LAST_BLOCK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_done && last_blk) |=> (!gen_mode && !hb_mode)); // R5
    AST_START_LOADS_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_CTRL && idle) |=> (len_q == $past(wdata[LEN_W-1:0]))); // R3
endmodule

// File: rtl/vdma_edge.sv
// Rising-edge detector for the horizontal-blank status.
// Assumes hblank_in is synchronous to clk.
module vdma_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic rise
);
    logic prev_q;

    // Remember the last sampled level
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level_in;
    end

    assign rise = level_in && !prev_q;
endmodule

// File: rtl/vdma_seq.sv
// Block sequencer: steps through the bytes of one block, one per clock,
// and raises a one-cycle stall request after each block.
// Assumes the source answers in the same cycle as the request.
module vdma_seq #(
    parameter int          OFS_W      = 13,
    parameter int          BLK_BYTES  = 16,
    parameter int          STALL_NORM = 8,
    parameter int          STALL_DBL  = 16,
    parameter logic [15:0] VRAM_BASE  = 16'h8000,
    localparam int         CNT_W      = $clog2(STALL_DBL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gen_mode,
    input  logic             hb_mode,
    input  logic             hb_rise,
    input  logic             last_blk,
    input  logic             double_speed,
    input  logic [15:0]      src_base,
    input  logic [OFS_W-1:0] dst_base,
    input  logic [7:0]       src_rd_data,
    output logic             busy,
    output logic             blk_done,
    output logic             src_rd_en,
    output logic [15:0]      src_rd_addr,
    output logic             vram_wr_en,
    output logic [15:0]      vram_wr_addr,
    output logic [7:0]       vram_wr_data,
    output logic             stall_req,
    output logic [CNT_W-1:0] stall_cycles
);
    localparam int             IDX_W   = $clog2(BLK_BYTES);
    localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(BLK_BYTES - 1);

    logic             active_q;
    logic [IDX_W-1:0] idx_q;
    logic             start;
    logic [OFS_W-1:0] ofs;

    assign start    = !active_q && (gen_mode || (hb_mode && hb_rise));
    assign blk_done = active_q && (idx_q == IDX_MAX);
    assign busy     = active_q;

    // Byte addresses of the current step
    assign ofs          = dst_base + OFS_W'(idx_q);
    assign src_rd_en    = active_q;
    assign src_rd_addr  = src_base + 16'(idx_q);
    assign vram_wr_en   = active_q;
    assign vram_wr_addr = VRAM_BASE | 16'(ofs);
    assign vram_wr_data = src_rd_data;

    // Byte counter: start, step, and chain the next block in general mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            idx_q    <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            idx_q    <= '0;
        end else if (active_q) begin
            if (idx_q == IDX_MAX) begin
                idx_q    <= '0;
                active_q <= gen_mode && !last_blk;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // Stall request and its length, one cycle after each block
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stall_req    <= 1'b0;
            stall_cycles <= '0;
        end else begin
            stall_req <= blk_done;
            if (blk_done)
                stall_cycles <= double_speed ? CNT_W'(STALL_DBL) : CNT_W'(STALL_NORM);
        end
    end

    AST_IDX_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && idx_q != IDX_MAX) |=> (active_q && idx_q == $past(idx_q) + 1'b1)); // R3
    AST_STALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        stall_req |=> !stall_req); // R9
    AST_HB_EDGE_START: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(active_q) && !$past(gen_mode)) |-> $past(hb_rise)); // R4
    AST_WR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        vram_wr_en |-> (vram_wr_addr >= VRAM_BASE
                        && vram_wr_addr <= VRAM_BASE + 16'((1 << OFS_W) - 1))); // R2
endmodule

// File: rtl/vram_block_dma.sv
// Top of the video memory block copy engine: wires the register file,
// the blank edge detector and the block sequencer together.
// Assumes a single clock domain and a same-cycle source memory.
module vram_block_dma #(
    parameter int          OFS_W      = 13,
    parameter int          BLK_BYTES  = 16,
    parameter int          STALL_NORM = 8,
    parameter int          STALL_DBL  = 16,
    parameter logic [15:0] VRAM_BASE  = 16'h8000
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               reg_wr_en,
    input  logic [2:0]                         reg_sel,
    input  logic [7:0]                         reg_wdata,
    output logic [7:0]                         reg_rdata,
    output logic                               src_rd_en,
    output logic [15:0]                        src_rd_addr,
    input  logic [7:0]                         src_rd_data,
    output logic                               vram_wr_en,
    output logic [15:0]                        vram_wr_addr,
    output logic [7:0]                         vram_wr_data,
    input  logic                               hblank_in,
    input  logic                               double_speed,
    output logic                               stall_req,
    output logic [$clog2(STALL_DBL + 1)-1:0]   stall_cycles
);
    logic             blk_done, busy, gen_mode, hb_mode, last_blk, hb_rise;
    logic [15:0]      src_base;
    logic [OFS_W-1:0] dst_base;

    vdma_regfile #(.OFS_W(OFS_W), .BLK_BYTES(BLK_BYTES)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .sel(reg_sel),
        .wdata(reg_wdata), .rdata(reg_rdata), .blk_done(blk_done), .busy(busy),
        .src_base(src_base), .dst_base(dst_base), .gen_mode(gen_mode),
        .hb_mode(hb_mode), .last_blk(last_blk)
    );

    vdma_edge u_edge (
        .clk(clk), .rst_n(rst_n), .level_in(hblank_in), .rise(hb_rise)
    );

    vdma_seq #(
        .OFS_W(OFS_W), .BLK_BYTES(BLK_BYTES), .STALL_NORM(STALL_NORM),
        .STALL_DBL(STALL_DBL), .VRAM_BASE(VRAM_BASE)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .gen_mode(gen_mode), .hb_mode(hb_mode),
        .hb_rise(hb_rise), .last_blk(last_blk), .double_speed(double_speed),
        .src_base(src_base), .dst_base(dst_base), .src_rd_data(src_rd_data),
        .busy(busy), .blk_done(blk_done), .src_rd_en(src_rd_en),
        .src_rd_addr(src_rd_addr), .vram_wr_en(vram_wr_en),
        .vram_wr_addr(vram_wr_addr), .vram_wr_data(vram_wr_data),
        .stall_req(stall_req), .stall_cycles(stall_cycles)
    );
endmodule

// File: tb/vram_block_dma_tb.sv
`timescale 1ns/1ps
module vram_block_dma_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [7:0]  reg_rdata;
    logic        src_rd_en;
    logic [15:0] src_rd_addr;
    logic [7:0]  src_rd_data;
    logic        vram_wr_en;
    logic [15:0] vram_wr_addr;
    logic [7:0]  vram_wr_data;
    logic        hblank_in = 1'b0;
    logic        double_speed = 1'b0;
    logic        stall_req;
    logic [4:0]  stall_cycles;

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    // Monitor state
    logic [15:0] exp_src = 0;
    logic [12:0] exp_dst = 0;
    logic [4:0]  exp_stall = 5'd8;
    int wr_count = 0, bad_writes = 0, stall_count = 0, bad_stall = 0;
    logic prev_stall = 1'b0;

    always #4 clk = ~clk;

    function automatic logic [7:0] src_byte(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    assign src_rd_data = src_byte(src_rd_addr);

    vram_block_dma dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_rd_en(src_rd_en),
        .src_rd_addr(src_rd_addr), .src_rd_data(src_rd_data),
        .vram_wr_en(vram_wr_en), .vram_wr_addr(vram_wr_addr),
        .vram_wr_data(vram_wr_data), .hblank_in(hblank_in),
        .double_speed(double_speed), .stall_req(stall_req),
        .stall_cycles(stall_cycles)
    );

    // Byte-write and stall monitor against the bench's own pointer model
    always @(negedge clk) begin
        if (rst_n) begin
            if (vram_wr_en) begin
                wr_count++;
                if (vram_wr_addr != (16'h8000 | {3'b000, exp_dst}) ||
                    vram_wr_data != src_byte(exp_src))
                    bad_writes++;
                exp_src = exp_src + 16'd1;
                exp_dst = exp_dst + 13'd1;
            end
            if (stall_req) begin
                stall_count++;
                if (stall_cycles != exp_stall || prev_stall) bad_stall++;
            end
            prev_stall = stall_req;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [7:0] d);
        @(negedge clk);
        reg_sel = s; reg_wdata = d; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] s, output logic [7:0] d);
        @(negedge clk);
        reg_sel = s;
        #1 d = reg_rdata;
    endtask

    task automatic clear_counts();
        #1;
        wr_count = 0; bad_writes = 0; stall_count = 0; bad_stall = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // {src_hi, src_lo, dst_hi, dst_lo, dbl, len, exp_blocks, exp_ctrl}
    localparam logic [55:0] VEC [4] = '{
        {8'h12, 8'h3F, 8'h01, 8'h00, 1'b0, 7'd0, 8'd1, 8'hFF},
        {8'hC0, 8'h07, 8'h10, 8'h05, 1'b1, 7'd3, 8'd4, 8'hFF},
        {8'hFF, 8'hF0, 8'h00, 8'h00, 1'b1, 7'd1, 8'd2, 8'hFF},
        {8'h40, 8'h00, 8'hFF, 8'hEC, 1'b0, 7'd5, 8'd2, 8'h83}
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state
        rd(3'd4, r); check("R7 ctrl after reset", r, 8'hFF);
        check("R3 no write after reset", vram_wr_en, 0);
        check("R9 no stall after reset", stall_req, 0);

        // Table of general-mode transfers
        for (int i = 0; i < 4; i++) begin
            logic [55:0] v;
            v = VEC[i];
            double_speed = v[23];
            wr(3'd0, v[55:48]); wr(3'd1, v[47:40]);
            wr(3'd2, v[39:32]); wr(3'd3, v[31:24]);
            exp_src   = {v[55:48], v[47:40] & 8'hF0};
            exp_dst   = {v[36:32], v[31:24] & 8'hF0};
            exp_stall = v[23] ? 5'd16 : 5'd8;
            clear_counts();
            wr(3'd4, {1'b0, v[22:16]});
            idle(16 * int'(v[15:8]) + 20);
            check($sformatf("R3 vec%0d byte count", i), wr_count, 16 * int'(v[15:8]));
            check($sformatf("R1 R2 vec%0d bytes", i), bad_writes, 0);
            check($sformatf("R9 vec%0d stall pulses", i), stall_count, int'(v[15:8]));
            check($sformatf("R9 vec%0d stall value", i), bad_stall, 0);
            rd(3'd4, r);
            check($sformatf("R5 R6 R7 vec%0d ctrl", i), r, v[7:0]);
        end

        // Offset wrapped to 0 after the window end: next transfer starts at 0x8000
        double_speed = 1'b0; exp_stall = 5'd8;
        wr(3'd0, 8'h20); wr(3'd1, 8'h00);
        exp_src = 16'h2000; exp_dst = 13'h0000;
        clear_counts();
        wr(3'd4, 8'h00);
        idle(40);
        check("R6 wrapped offset count", wr_count, 16);
        check("R6 wrapped offset bytes", bad_writes, 0);

        // Register reads return 0xFF
        rd(3'd0, r); check("R10 src hi read", r, 8'hFF);
        rd(3'd1, r); check("R10 src lo read", r, 8'hFF);
        rd(3'd2, r); check("R10 dst hi read", r, 8'hFF);
        rd(3'd3, r); check("R10 dst lo read", r, 8'hFF);
        rd(3'd6, r); check("R10 unused read", r, 8'hFF);

        // Blank-paced mode, started while the blank level is already high
        hblank_in = 1'b1;
        wr(3'd0, 8'h33); wr(3'd1, 8'h50); wr(3'd2, 8'h04); wr(3'd3, 8'h40);
        exp_src = 16'h3350; exp_dst = 13'h0440;
        clear_counts();
        wr(3'd4, 8'h82);
        idle(30);
        check("R4 level without edge", wr_count, 0);
        rd(3'd4, r); check("R7 blank mode active ctrl", r, 8'h02);
        hblank_in = 1'b0; idle(5); hblank_in = 1'b1; idle(40);
        check("R4 first edge block", wr_count, 16);
        rd(3'd4, r); check("R7 blank after one block", r, 8'h01);
        hblank_in = 1'b0; idle(5); hblank_in = 1'b1; idle(40);
        check("R4 second edge block", wr_count, 32);
        check("R4 blank bytes", bad_writes, 0);
        check("R9 blank stall pulses", stall_count, 2);
        // Cancel, then an edge must copy nothing
        wr(3'd4, 8'h00);
        rd(3'd4, r); check("R8 cancel ctrl", r, 8'h80);
        hblank_in = 1'b0; idle(5); hblank_in = 1'b1; idle(40);
        check("R8 no block after cancel", wr_count, 32);
        hblank_in = 1'b0;

        // Control write during a general transfer is ignored
        double_speed = 1'b1; exp_stall = 5'd16;
        wr(3'd0, 8'h05); wr(3'd1, 8'h00); wr(3'd2, 8'h02); wr(3'd3, 8'h00);
        exp_src = 16'h0500; exp_dst = 13'h0200;
        clear_counts();
        wr(3'd4, 8'h03);
        idle(4);
        wr(3'd4, 8'h85);
        idle(90);
        check("R8 general not disturbed count", wr_count, 64);
        check("R8 general bytes", bad_writes, 0);
        check("R9 double speed stall", bad_stall, 0);
        rd(3'd4, r); check("R8 ctrl after ignored write", r, 8'hFF);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule